// File: doc/BRIEF.md
# Packet Capture Record Formatter

This block turns received Ethernet frames into capture records ready to be written to a trace buffer. Frames arrive one byte per cycle, with valid, start and end strobes. A 64-bit arrival time is sampled on the first byte of each frame. For each accepted frame the block emits a 16-byte header followed by the captured bytes. The header holds the timestamp, a record type constant, a flags byte, the record length, a count of frames lost and the length of the frame on the wire. Records follow one another with nothing in between, so a consumer can split the output stream at any record boundary.

The input side cannot be stalled. A frame is first stored in an internal byte buffer, because both length fields are known only once its last byte has arrived. The header and payload are then sent out under valid/ready flow control. A snap length limits how many bytes of each frame are kept. When fixed-length mode is on, every record carries exactly the snap length, and short frames are filled with pad bytes. A frame that begins while the previous record is still being sent is dropped whole and counted.

Top module: `capture_rec_fmt`

## Requirements
- R1: Header bytes 0 to 7 carry the timestamp sampled on the frame's first byte, least significant byte first.
- R2: Header byte 8 equals the parameter REC_TYPE. In header byte 9, bit 0 is set when the frame was truncated, and bits 7:1 are zero.
- R3: Header bytes 10-11 hold the record length (16 plus the payload bytes), most significant byte first. Bytes 14-15 hold the full wire length of the frame, most significant byte first.
- R4: The payload follows the header: exactly record length minus 16 bytes, in arrival order and without reordering. This includes a single-byte frame.
- R5: A frame longer than snap_len (1 to DEPTH) keeps only its first snap_len bytes and is flagged as truncated. A frame of exactly snap_len bytes is neither truncated nor flagged.
- R6: With fix_mode high, a shorter frame is followed by PAD bytes (0x00 by default), so the payload is snap_len bytes. With fix_mode low, no padding is added.
- R7: out_last is high only on the final byte of a record. While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R8: A frame whose first byte arrives while a record is being sent is dropped whole. Each drop increments a counter that saturates at 0xFFFF. The counter value appears in bytes 12-13 (most significant byte first) of the next record and is then cleared.
- R9: After reset, out_valid is low.
- R10: Valid bytes that arrive outside a frame, with no start strobe, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_len | input | 16 | Maximum number of bytes kept from each frame, 1 to DEPTH |
| fix_mode | input | 1 | Pad every record to snap_len |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Input byte |
| in_ts | input | 64 | Arrival time, sampled with in_sof |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Final byte of the record |

## Verification
The assertions rely on well-formed input framing. Every frame is at least one byte long, in_sof is set only on its first byte and in_eof only on its last, and no start strobe appears inside a frame that is still being received. They also rely on snap_len and fix_mode changing only between frames, and on snap_len staying within 1 to DEPTH. The bench builds each frame in a single task that raises the strobes only at the frame's edges. It changes the configuration only while the input is idle. The drop cases start new frames only after an accepted frame has fully arrived.

// File: rtl/capture_rec_fmt.sv
module capture_rec_fmt #(
  parameter int DEPTH = 256,
  parameter logic [7:0] REC_TYPE = 8'h02,
  parameter logic [7:0] PAD = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] snap_len,
  input  logic        fix_mode,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic [63:0] in_ts,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_EMIT} st_t;
  st_t st;

  logic [7:0]  mem [DEPTH];
  logic [63:0] ts_q;
  logic [15:0] wcnt, snap_q, loss_cnt, loss_q, wlen_q, rlen_q, clen_q, ocnt;
  logic        fix_q, trunc_q;

  logic        acc, beat, done, drop, xfer, fix_e;
  logic [15:0] widx, wnext, snap_e, clen_n, pidx;

  assign acc    = in_valid && in_sof && st == S_IDLE;
  assign beat   = in_valid && (acc || st == S_CAPT);
  assign done   = beat && in_eof;
  assign drop   = in_valid && in_sof && st == S_EMIT;
  assign widx   = acc ? 16'd0 : wcnt;
  assign snap_e = acc ? snap_len : snap_q;
  assign fix_e  = acc ? fix_mode : fix_q;
  assign wnext  = acc ? 16'd1 : ((&wcnt) ? wcnt : wcnt + 16'd1);
  assign clen_n = (wnext > snap_e) ? snap_e : wnext;

  assign out_valid = st == S_EMIT;
  assign xfer      = out_valid && out_ready;
  assign out_last  = out_valid && ocnt >= 16'd16 && ocnt == rlen_q - 16'd1;
  assign pidx      = ocnt - 16'd16;

  always_ff @(posedge clk)
    if (beat && widx < snap_e) mem[widx[AW-1:0]] <= in_data;

  always_comb begin
    out_data = PAD;
    if (ocnt < 16'd16) begin
      if (!ocnt[3]) out_data = ts_q[{ocnt[2:0], 3'b000} +: 8];
      else begin
        case (ocnt[2:0])
          3'd0: out_data = REC_TYPE;
          3'd1: out_data = {7'd0, trunc_q};
          3'd2: out_data = rlen_q[15:8];
          3'd3: out_data = rlen_q[7:0];
          3'd4: out_data = loss_q[15:8];
          3'd5: out_data = loss_q[7:0];
          3'd6: out_data = wlen_q[15:8];
          default: out_data = wlen_q[7:0];
        endcase
      end
    end else if (pidx < clen_q) begin
      out_data = mem[pidx[AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ts_q     <= '0;
      wcnt     <= '0;
      snap_q   <= '0;
      fix_q    <= 1'b0;
      loss_cnt <= '0;
      loss_q   <= '0;
      wlen_q   <= '0;
      rlen_q   <= '0;
      clen_q   <= '0;
      trunc_q  <= 1'b0;
      ocnt     <= '0;
    end else begin
      if (acc) begin
        ts_q   <= in_ts;
        snap_q <= snap_len;
        fix_q  <= fix_mode;
      end
      if (beat) begin
        wcnt <= wnext;
        st   <= in_eof ? S_EMIT : S_CAPT;
      end
      if (done) begin
        wlen_q   <= wnext;
        clen_q   <= clen_n;
        trunc_q  <= wnext > snap_e;
        rlen_q   <= 16'd16 + (fix_e ? snap_e : clen_n);
        loss_q   <= loss_cnt;
        loss_cnt <= '0;
        ocnt     <= '0;
      end else if (drop && !(&loss_cnt)) begin
        loss_cnt <= loss_cnt + 16'd1;
      end
      if (xfer) begin
        if (out_last) begin
          st   <= S_IDLE;
          ocnt <= '0;
        end else begin
          ocnt <= ocnt + 16'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rec_fmt_chk.sv
module rec_fmt_chk #(
  parameter logic [7:0] REC_TYPE = 8'h02
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic [7:0] out_data
);
  logic [15:0] idx;
  logic [7:0]  rl_hi, rl_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      rl_hi <= '0;
      rl_lo <= '0;
    end else if (out_valid && out_ready) begin
      idx <= out_last ? 16'd0 : idx + 16'd1;
      if (idx == 16'd10) rl_hi <= out_data;
      if (idx == 16'd11) rl_lo <= out_data;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R7
  no_last_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx < 16'd16 |-> !out_last);

  // R2
  type_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == 16'd8 |-> out_data == REC_TYPE);

  // R2
  flag_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == 16'd9 |-> out_data[7:1] == 7'd0);

  // R4
  rec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> idx == {rl_hi, rl_lo} - 16'd1);
endmodule

bind capture_rec_fmt rec_fmt_chk #(.REC_TYPE(REC_TYPE)) u_rec_fmt_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_data(out_data)
);

// File: tb/capture_rec_fmt_bench.sv
`timescale 1ns/1ps
module capture_rec_fmt_bench;
  localparam logic [7:0] TYPE_C = 8'h02;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] snap_len = 16'd64;
  logic        fix_mode = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic [63:0] in_ts = 64'd0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  capture_rec_fmt u_capture_rec_fmt (
    .clk(clk), .rst_n(rst_n), .snap_len(snap_len), .fix_mode(fix_mode),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_ts(in_ts), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int fails = 0;
  int bp_mode = 0;
  logic [7:0] got_d[$];
  logic       got_l[$];

  always @(negedge clk) begin
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = 1'b0;
    endcase
    #0.5;
    if (rst_n && out_valid && out_ready) begin
      got_d.push_back(out_data);
      got_l.push_back(out_last);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [7:0] seed, input int i);
    return 8'(seed + i * 3);
  endfunction

  task automatic send(input int n, input logic [63:0] ts, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_data  = fbyte(seed, i);
      in_ts    = ts + 64'(i * 5);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic check_rec(input string req, input logic [63:0] ts, input int wlen,
                           input logic [7:0] seed, input int snap, input bit fix,
                           input int loss);
    int cap, pay, rlen, bad, lastbad;
    logic [7:0] b[$];
    logic       l[$];
    logic [63:0] gts;
    logic [7:0] e;
    cap  = (wlen > snap) ? snap : wlen;
    pay  = fix ? snap : cap;
    rlen = 16 + pay;
    while (got_d.size() < rlen) @(negedge clk);
    for (int i = 0; i < rlen; i++) begin
      b.push_back(got_d.pop_front());
      l.push_back(got_l.pop_front());
    end
    gts = '0;
    for (int i = 0; i < 8; i++) gts[8*i +: 8] = b[i];
    chk(gts == ts, "R1", "timestamp", gts, ts);
    chk(b[8] == TYPE_C, "R2", "type", b[8], TYPE_C);
    chk(b[9] == {7'd0, wlen > snap}, "R2", "flags", b[9], {7'd0, wlen > snap});
    chk({b[10], b[11]} == 16'(rlen), "R3", "rlen", {b[10], b[11]}, rlen);
    chk({b[12], b[13]} == 16'(loss), "R8", "loss", {b[12], b[13]}, loss);
    chk({b[14], b[15]} == 16'(wlen), "R3", "wlen", {b[14], b[15]}, wlen);
    bad = 0;
    for (int i = 0; i < pay; i++) begin
      e = (i < cap) ? fbyte(seed, i) : 8'h00;
      if (b[16 + i] != e) bad++;
    end
    chk(bad == 0, req, "payload mismatches", bad, 0);
    lastbad = 0;
    for (int i = 0; i < rlen; i++) if (l[i] != (i == rlen - 1)) lastbad++;
    chk(lastbad == 0, "R7", "last flag misplaced", lastbad, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(3);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_stray;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 5); in_data = 8'hA5;
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    idle(5);
    chk(out_valid == 1'b0 && got_d.size() == 0, "R10", "output from stray bytes",
        got_d.size(), 0);
  endtask

  task automatic t_basic;
    bp_mode = 0; snap_len = 16'd64; fix_mode = 1'b0;
    send(20, 64'h1122_3344_5566_7788, 8'h10);
    check_rec("R4", 64'h1122_3344_5566_7788, 20, 8'h10, 64, 1'b0, 0);
    send(1, 64'hDEAD_BEEF_0000_0001, 8'h77);
    check_rec("R4", 64'hDEAD_BEEF_0000_0001, 1, 8'h77, 64, 1'b0, 0);
  endtask

  task automatic t_trunc;
    bp_mode = 0; snap_len = 16'd32; fix_mode = 1'b0;
    send(100, 64'h0A0B_0C0D_0E0F_1011, 8'h03);
    check_rec("R5", 64'h0A0B_0C0D_0E0F_1011, 100, 8'h03, 32, 1'b0, 0);
    idle(2); snap_len = 16'd256;
    send(256, 64'h5, 8'h40);
    check_rec("R5", 64'h5, 256, 8'h40, 256, 1'b0, 0);
    send(257, 64'h6, 8'h41);
    check_rec("R5", 64'h6, 257, 8'h41, 256, 1'b0, 0);
  endtask

  task automatic t_fixed;
    bp_mode = 0; snap_len = 16'd24; fix_mode = 1'b1;
    send(10, 64'h77, 8'hC0);
    check_rec("R6", 64'h77, 10, 8'hC0, 24, 1'b1, 0);
    send(40, 64'h78, 8'hC1);
    check_rec("R6", 64'h78, 40, 8'hC1, 24, 1'b1, 0);
    idle(2); fix_mode = 1'b0;
  endtask

  task automatic t_backpressure;
    bp_mode = 1; snap_len = 16'd64; fix_mode = 1'b0;
    send(50, 64'hFEDC_BA98_7654_3210, 8'h22);
    check_rec("R7", 64'hFEDC_BA98_7654_3210, 50, 8'h22, 64, 1'b0, 0);
    bp_mode = 0;
  endtask

  task automatic t_drop;
    bp_mode = 2; snap_len = 16'd64; fix_mode = 1'b0;
    send(12, 64'hA0, 8'h01);
    idle(3);
    send(4, 64'hB0, 8'h02);
    send(6, 64'hC0, 8'h03);
    idle(2);
    bp_mode = 0;
    check_rec("R8", 64'hA0, 12, 8'h01, 64, 1'b0, 0);
    idle(2);
    chk(got_d.size() == 0, "R8", "bytes of dropped frames", got_d.size(), 0);
    send(8, 64'hD0, 8'h04);
    check_rec("R8", 64'hD0, 8, 8'h04, 64, 1'b0, 2);
    send(8, 64'hE0, 8'h05);
    check_rec("R8", 64'hE0, 8, 8'h05, 64, 1'b0, 0);
  endtask

  task automatic t_saturate;
    bp_mode = 2;
    send(5, 64'hF0, 8'h06);
    idle(2);
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h99;
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    bp_mode = 0;
    check_rec("R8", 64'hF0, 5, 8'h06, 64, 1'b0, 0);
    send(3, 64'hF1, 8'h07);
    check_rec("R8", 64'hF1, 3, 8'h07, 64, 1'b0, 65535);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_stray();
    t_basic();
    t_trunc();
    t_fixed();
    t_backpressure();
    t_drop();
    t_saturate();
    idle(4);
    chk(got_d.size() == 0, "R4", "extra output bytes", got_d.size(), 0);
    finish_run();
  end
endmodule